// File: doc/BRIEF.md
# Serial-Commanded Bipolar Avionics Word Transmitter

This block takes 32-bit words from a host over a four-wire serial command port (SPI, mode 0) and sends them on an ARINC 429 style bipolar line as return-to-zero frames. The host sends a one-byte command, followed by any data bytes. Commands write a control register, push data words into a 32-entry queue, clear the queue, reset the block, start a transmit burst, and read back the control and status registers. The serial pins are sampled by the block's own master clock, which also times the line bits.

Each bit on the line spends its first half at HIGH or LOW and its second half at NULL. Words are separated by a NULL gap that is at least four bit times long. In manual mode, queued words wait for a start command and then drain as one burst. In automatic mode, the transmitter sends whenever the queue is not empty. A flag pin shows the queue state. The line state is given as two digital outputs, and the analog drivers are outside this block.

Top module: `arinc_tx_spi`

## Requirements
- R1: Serial framing is SPI mode 0. `spi_cs_n` is active low, MOSI is sampled on SCK rising edges with the MSB first, and MISO changes on SCK falling edges. The first 8 bits are the command code. A command whose last bit never arrives before `spi_cs_n` rises has no effect.
- R2: Command 0x01 acts after its 8th bit. It clears the control register to 0, empties the queue and returns the line to NULL. After reset (pin or command) the line is NULL and the status reads 0x01.
- R3: Command 0x10 is followed by 16 control bits, MSB first, which are written after the last bit. Command 0x0C shifts the 16-bit control register out on MISO.
- R4: Command 0x0E is followed by 32 data bits, MSB first, and pushes one word. A push made while the queue is full is discarded.
- R5: Command 0x02 empties the queue after its 8th bit, without changing the control register.
- R6: Command 0x0A shifts out one status byte. Bit 0 is queue empty, bit 1 is queue full, bit 2 is transmitter busy (frame or gap in progress), and bits 7..3 are 0.
- R7: With control bit 13 at 0, queued words are not sent until command 0x12. After 0x12 the queue drains completely. Once the queue is empty and the line is idle, later words wait for a new 0x12.
- R8: With control bit 13 at 1, words are sent as soon as the queue holds any.
- R9: `line_hi` and `line_lo` are never high together. A bit drives HIGH (data 1) or LOW (data 0) for `HALF_HS` clocks at high speed, then drives NULL (both low) for the second half.
- R10: Bit order on the line: word bits 7 down to 0 first, then bits 8 up to 31.
- R11: With control bit 10 at 0, a bit lasts 2*`HALF_HS` clocks. With control bit 10 at 1, a bit lasts 8 times longer.
- R12: The starts of consecutive words in one burst are at least 36 bit times apart, which leaves at least 4 NULL bit times between words.
- R13: `tx_flag` shows queue empty while control bit 14 is 0, and queue full while control bit 14 is 1.
- R14: The queue holds 32 words and sends them in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| tx_flag | output | 1 | Queue empty or full indicator |
| line_hi | output | 1 | Line at HIGH level |
| line_lo | output | 1 | Line at LOW level |

## Verification
A table of six words drives the main function. The words include all-ones, all-zeros, alternating bits and words whose label byte differs from the rest. Together they separate a correct label-reversed bit order from a plain LSB-first or MSB-first order, and they expose lost or duplicated words in a burst. Directed runs then cover the remaining behaviour:
- a full queue plus one extra push, which shows whether the overflow word is dropped;
- commands cut short by an early rise of `spi_cs_n`, which shows that effects wait for the last bit;
- automatic mode, which shows sending with no start command;
- the slow rate, which separates the two bit periods.

// File: rtl/arinc_tx_pkg.sv
package arinc_tx_pkg;
    localparam logic [7:0] OP_RESET     = 8'h01;
    localparam logic [7:0] OP_CLEAR     = 8'h02;
    localparam logic [7:0] OP_RD_STATUS = 8'h0A;
    localparam logic [7:0] OP_RD_CTRL   = 8'h0C;
    localparam logic [7:0] OP_WR_DATA   = 8'h0E;
    localparam logic [7:0] OP_WR_CTRL   = 8'h10;
    localparam logic [7:0] OP_ENABLE    = 8'h12;

    localparam int CTRL_W        = 16;
    localparam int CB_SLOW       = 10;
    localparam int CB_AUTO       = 13;
    localparam int CB_FLAG_FULL  = 14;

    typedef enum logic [1:0] {TX_IDLE, TX_BIT, TX_GAP} tx_state_e;
endpackage

// File: rtl/arinc_spi_port.sv
module arinc_spi_port
    import arinc_tx_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              mosi_i,
    input  logic [7:0]        status_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              miso_o,
    output logic              do_reset_o,
    output logic              do_clear_o,
    output logic              do_enable_o,
    output logic              ctrl_we_o,
    output logic [CTRL_W-1:0] ctrl_wdata_o,
    output logic              data_we_o,
    output logic [WORD_W-1:0] data_wdata_o
);
    localparam int CNT_MAX = 8 + WORD_W;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int OUT_W   = (CTRL_W > 8) ? CTRL_W : 8;
    localparam logic [CNT_W-1:0] LAST_OP   = CNT_W'(7);
    localparam logic [CNT_W-1:0] LAST_CTRL = CNT_W'(8 + CTRL_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(8 + WORD_W - 1);
    localparam logic [CNT_W-1:0] CNT_TOP   = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] CNT_BYTE  = CNT_W'(8);

    typedef struct packed {
        logic [2:0]        sck_sr;
        logic [1:0]        cs_sr;
        logic [1:0]        mosi_sr;
        logic [CNT_W-1:0]  cnt;
        logic [7:0]        opcode;
        logic [WORD_W-1:0] in_sr;
        logic [OUT_W-1:0]  out_sr;
        logic              miso;
        logic              do_reset;
        logic              do_clear;
        logic              do_enable;
        logic              ctrl_we;
        logic              data_we;
    } spi_st_t;

    spi_st_t q, d;
    logic rise, fall;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        d = q;
        d.sck_sr  = {q.sck_sr[1:0], sck_i};
        d.cs_sr   = {q.cs_sr[0], cs_n_i};
        d.mosi_sr = {q.mosi_sr[0], mosi_i};
        d.do_reset  = 1'b0;
        d.do_clear  = 1'b0;
        d.do_enable = 1'b0;
        d.ctrl_we   = 1'b0;
        d.data_we   = 1'b0;
        rise    = q.sck_sr[1] & ~q.sck_sr[2];
        fall    = ~q.sck_sr[1] & q.sck_sr[2];
        shifted = {q.in_sr[WORD_W-2:0], q.mosi_sr[1]};
        if (q.cs_sr[1]) begin
            d.cnt    = '0;
            d.out_sr = '0;
            d.miso   = 1'b0;
        end else if (rise) begin
            d.in_sr = shifted;
            if (q.cnt != CNT_TOP) d.cnt = q.cnt + CNT_W'(1);
            if (q.cnt == LAST_OP) begin
                d.opcode = shifted[7:0];
                case (shifted[7:0])
                    OP_RESET:     d.do_reset  = 1'b1;
                    OP_CLEAR:     d.do_clear  = 1'b1;
                    OP_ENABLE:    d.do_enable = 1'b1;
                    OP_RD_STATUS: d.out_sr = OUT_W'(status_i) << (OUT_W - 8);
                    OP_RD_CTRL:   d.out_sr = OUT_W'(ctrl_i) << (OUT_W - CTRL_W);
                    default:      d.out_sr = '0;
                endcase
            end
            if (q.cnt == LAST_CTRL && q.opcode == OP_WR_CTRL) d.ctrl_we = 1'b1;
            if (q.cnt == LAST_DATA && q.opcode == OP_WR_DATA) d.data_we = 1'b1;
        end else if (fall && q.cnt >= CNT_BYTE) begin
            d.miso   = q.out_sr[OUT_W-1];
            d.out_sr = {q.out_sr[OUT_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cs_sr <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign miso_o       = q.miso;
    assign do_reset_o   = q.do_reset;
    assign do_clear_o   = q.do_clear;
    assign do_enable_o  = q.do_enable;
    assign ctrl_we_o    = q.ctrl_we;
    assign ctrl_wdata_o = q.in_sr[CTRL_W-1:0];
    assign data_we_o    = q.data_we;
    assign data_wdata_o = q.in_sr;

    // R1
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_reset_o, do_clear_o, do_enable_o, ctrl_we_o, data_we_o}));

    // R1
    miso_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cs_sr[1] && $past(q.cs_sr[1])) |=> !miso_o);
endmodule

// File: rtl/arinc_word_fifo.sv
module arinc_word_fifo #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              empty_o,
    output logic              full_o,
    output logic [$clog2(DEPTH):0] count_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW:0] wr;
        logic [AW:0] rd;
    } ptr_st_t;

    ptr_st_t q, d;
    logic [WORD_W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign empty_o = (q.wr == q.rd);
    assign full_o  = (q.wr[AW] != q.rd[AW]) && (q.wr[AW-1:0] == q.rd[AW-1:0]);
    assign count_o = q.wr - q.rd;
    assign rdata_o = mem[q.rd[AW-1:0]];

    always_comb begin
        d       = q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (clear_i) begin
            d = '0;
        end else begin
            if (do_push) d.wr = q.wr + (AW+1)'(1);
            if (do_pop)  d.rd = q.rd + (AW+1)'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !clear_i) mem[q.wr[AW-1:0]] <= wdata_i;
    end

    // R4
    full_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i && !clear_i) |=> $stable(count_o));

    // R14
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= ($clog2(DEPTH)+1)'(DEPTH));

    // R14
    pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !clear_i) |-> !empty_o);
endmodule

// File: rtl/arinc_frame_tx.sv
module arinc_frame_tx
    import arinc_tx_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int HALF_HS    = 5,
    parameter int SLOW_RATIO = 8,
    parameter int GAP_BITS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              go_i,
    input  logic              slow_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              load_o,
    output logic              busy_o,
    output logic              line_hi_o,
    output logic              line_lo_o
);
    localparam int HALF_LS = HALF_HS * SLOW_RATIO;
    localparam int HC_W    = $clog2(HALF_LS + 1);
    localparam int IDX_MAX = (WORD_W > 2*GAP_BITS) ? WORD_W : 2*GAP_BITS;
    localparam int IDX_W   = $clog2(IDX_MAX);
    localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LAST_GAP = IDX_W'(2*GAP_BITS - 1);

    typedef struct packed {
        tx_state_e         state;
        logic [WORD_W-1:0] word;
        logic              slow;
        logic [HC_W-1:0]   half_cnt;
        logic              second;
        logic [IDX_W-1:0]  idx;
        logic              hi;
        logic              lo;
    } tx_st_t;

    tx_st_t q, d;
    logic [HC_W-1:0] half_max;
    logic            nb;

    function automatic logic bit_at(input logic [WORD_W-1:0] w, input logic [IDX_W-1:0] k);
        logic [IDX_W-1:0] pos;
        pos = (k < IDX_W'(8)) ? (IDX_W'(7) - k) : k;
        return w[pos];
    endfunction

    always_comb begin
        d        = q;
        load_o   = 1'b0;
        nb       = 1'b0;
        half_max = q.slow ? HC_W'(HALF_LS - 1) : HC_W'(HALF_HS - 1);
        if (abort_i) begin
            d       = '0;
            d.state = TX_IDLE;
        end else begin
            case (q.state)
                TX_IDLE: begin
                    if (go_i) begin
                        load_o     = 1'b1;
                        d.word     = word_i;
                        d.slow     = slow_i;
                        d.state    = TX_BIT;
                        d.idx      = '0;
                        d.second   = 1'b0;
                        d.half_cnt = '0;
                        nb         = bit_at(word_i, '0);
                        d.hi       = nb;
                        d.lo       = ~nb;
                    end
                end
                TX_BIT: begin
                    if (q.half_cnt == half_max) begin
                        d.half_cnt = '0;
                        if (!q.second) begin
                            d.second = 1'b1;
                            d.hi     = 1'b0;
                            d.lo     = 1'b0;
                        end else begin
                            d.second = 1'b0;
                            if (q.idx == LAST_BIT) begin
                                d.state = TX_GAP;
                                d.idx   = '0;
                            end else begin
                                d.idx = q.idx + IDX_W'(1);
                                nb    = bit_at(q.word, q.idx + IDX_W'(1));
                                d.hi  = nb;
                                d.lo  = ~nb;
                            end
                        end
                    end else begin
                        d.half_cnt = q.half_cnt + HC_W'(1);
                    end
                end
                TX_GAP: begin
                    if (q.half_cnt == half_max) begin
                        d.half_cnt = '0;
                        if (q.idx == LAST_GAP) begin
                            d.state = TX_IDLE;
                            d.idx   = '0;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end else begin
                        d.half_cnt = q.half_cnt + HC_W'(1);
                    end
                end
                default: d.state = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= TX_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy_o    = (q.state != TX_IDLE);
    assign line_hi_o = q.hi;
    assign line_lo_o = q.lo;

    // R9
    line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_hi_o && line_lo_o));

    // R12
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !abort_i) |=> (busy_o && (line_hi_o || line_lo_o)));
endmodule

// File: rtl/arinc_tx_spi.sv
module arinc_tx_spi
    import arinc_tx_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int FIFO_DEPTH = 32,
    parameter int HALF_HS    = 5,
    parameter int SLOW_RATIO = 8,
    parameter int GAP_BITS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic tx_flag,
    output logic line_hi,
    output logic line_lo
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic              armed;
    } top_st_t;

    top_st_t q, d;

    logic              do_reset, do_clear, do_enable, ctrl_we, data_we;
    logic [CTRL_W-1:0] ctrl_wdata;
    logic [WORD_W-1:0] data_wdata, fifo_rdata;
    logic              fifo_empty, fifo_full, tx_load, tx_busy, tx_go;
    logic [CNT_W-1:0]  fifo_count;
    logic [7:0]        status;

    assign status  = {5'b0, tx_busy, fifo_full, fifo_empty};
    assign tx_go   = !fifo_empty && (q.ctrl[CB_AUTO] || q.armed);
    assign tx_flag = q.ctrl[CB_FLAG_FULL] ? fifo_full : fifo_empty;

    always_comb begin
        d = q;
        if (do_reset) begin
            d = '0;
        end else begin
            if (ctrl_we) d.ctrl = ctrl_wdata;
            if (do_enable && !q.ctrl[CB_AUTO]) d.armed = 1'b1;
            else if (q.armed && fifo_empty && !tx_busy) d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    arinc_spi_port #(.WORD_W(WORD_W)) u_port (
        .clk(clk), .rst_n(rst_n),
        .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
        .status_i(status), .ctrl_i(q.ctrl),
        .miso_o(spi_miso),
        .do_reset_o(do_reset), .do_clear_o(do_clear), .do_enable_o(do_enable),
        .ctrl_we_o(ctrl_we), .ctrl_wdata_o(ctrl_wdata),
        .data_we_o(data_we), .data_wdata_o(data_wdata)
    );

    arinc_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .clear_i(do_clear || do_reset),
        .push_i(data_we), .wdata_i(data_wdata),
        .pop_i(tx_load), .rdata_o(fifo_rdata),
        .empty_o(fifo_empty), .full_o(fifo_full), .count_o(fifo_count)
    );

    arinc_frame_tx #(
        .WORD_W(WORD_W), .HALF_HS(HALF_HS),
        .SLOW_RATIO(SLOW_RATIO), .GAP_BITS(GAP_BITS)
    ) u_tx (
        .clk(clk), .rst_n(rst_n),
        .abort_i(do_reset), .go_i(tx_go), .slow_i(q.ctrl[CB_SLOW]),
        .word_i(fifo_rdata), .load_o(tx_load), .busy_o(tx_busy),
        .line_hi_o(line_hi), .line_lo_o(line_lo)
    );

    // R2
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_reset |=> (q.ctrl == '0 && fifo_empty && !line_hi && !line_lo));

    // R7
    manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ctrl[CB_AUTO] && !q.armed && !do_reset) |-> !tx_load);
endmodule

// File: tb/arinc_tx_spi_bench.sv
module arinc_tx_spi_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_HS    = 5;
    localparam int SCK_HALF   = 8;
    localparam int BIT_HS     = 2 * HALF_HS;

    // stimulus words; the expected decoded word on the line equals each entry
    localparam logic [31:0] VEC [6] = '{
        32'hFFFF_FFFF, 32'h0000_0000, 32'hAAAA_5555,
        32'h1234_5680, 32'h8000_0001, 32'h0F0F_F0C3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso, tflag, lhi, llo;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    arinc_tx_spi #(.HALF_HS(HALF_HS)) u_arinc_tx_spi (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .tx_flag(tflag),
        .line_hi(lhi), .line_lo(llo)
    );

    // line monitor
    int          rx_n = 0;
    logic [31:0] rx_w [64];
    longint      first_t [64];
    int          bit_k = 0;
    logic [31:0] cur = '0;
    longint      cyc = 0, prev_t = 0, last_period = 0, last_width = 0;
    logic        ph = 1'b0, pl = 1'b0;
    int          both_bad = 0;

    always @(negedge clk) begin
        cyc++;
        if (lhi && llo) both_bad++;
        if ((!lhi && ph) || (!llo && pl)) last_width = cyc - prev_t;
        if ((lhi && !ph) || (llo && !pl)) begin
            if (bit_k > 0) last_period = cyc - prev_t;
            if (bit_k == 0 && rx_n < 64) first_t[rx_n] = cyc;
            prev_t = cyc;
            cur[(bit_k < 8) ? (7 - bit_k) : bit_k] = lhi;
            bit_k++;
            if (bit_k == 32) begin
                if (rx_n < 64) rx_w[rx_n] = cur;
                rx_n++;
                bit_k = 0;
            end
        end
        ph = lhi;
        pl = llo;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bit_io(input logic v, output logic b);
        mosi = v;
        repeat (SCK_HALF) @(negedge clk);
        b = miso;
        sck = 1'b1;
        repeat (SCK_HALF) @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic spi_xfer(input logic [7:0] op, input int nop, input logic [31:0] dat,
                            input int ndat, output logic [31:0] rd);
        logic b;
        rd = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (SCK_HALF) @(negedge clk);
        for (int i = 0; i < nop; i++) bit_io(op[7-i], b);
        for (int i = 0; i < ndat; i++) begin
            bit_io(dat[ndat-1-i], b);
            rd = {rd[30:0], b};
        end
        repeat (SCK_HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (SCK_HALF) @(negedge clk);
    endtask

    task automatic op_only(input logic [7:0] op);
        logic [31:0] r;
        spi_xfer(op, 8, 32'h0, 0, r);
    endtask

    task automatic wr_ctrl(input logic [15:0] c);
        logic [31:0] r;
        spi_xfer(8'h10, 8, {16'h0, c}, 16, r);
    endtask

    task automatic wr_data(input logic [31:0] w);
        logic [31:0] r;
        spi_xfer(8'h0E, 8, w, 32, r);
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [31:0] r;
        spi_xfer(8'h0A, 8, 32'h0, 8, r);
        s = r[7:0];
    endtask

    task automatic rd_ctrl(output logic [15:0] c);
        logic [31:0] r;
        spi_xfer(8'h0C, 8, 32'h0, 16, r);
        c = r[15:0];
    endtask

    task automatic wait_rx(input int target, input int limit);
        for (int i = 0; i < limit && rx_n < target; i++) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", rx_n, -1);
        finish_up();
    end

    initial begin
        logic [7:0]  st;
        logic [15:0] cr;
        logic [31:0] dummy;
        int          base;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // R2 / R13 reset state
        chk(!lhi && !llo, "R2 line null after reset", {lhi, llo}, 0);
        chk(tflag == 1'b1, "R13 flag shows empty after reset", tflag, 1);
        rd_status(st);
        chk(st == 8'h01, "R6 status after reset", st, 8'h01);

        // R3 control write and read-back
        wr_ctrl(16'hA5C3);
        rd_ctrl(cr);
        chk(cr == 16'hA5C3, "R3 control readback", cr, 16'hA5C3);
        // R1 reset command cut after 7 bits does nothing
        spi_xfer(8'h01, 7, 32'h0, 0, dummy);
        rd_ctrl(cr);
        chk(cr == 16'hA5C3, "R1 truncated reset ignored", cr, 16'hA5C3);
        // R2 reset command clears control
        op_only(8'h01);
        rd_ctrl(cr);
        chk(cr == 16'h0000, "R2 reset command clears control", cr, 0);

        // table walk: manual mode burst
        foreach (VEC[i]) wr_data(VEC[i]);
        repeat (500) @(negedge clk);
        chk(rx_n == 0, "R7 words held before start", rx_n, 0);
        rd_status(st);
        chk(st == 8'h00, "R6 status with queued words", st, 8'h00);
        spi_xfer(8'h12, 7, 32'h0, 0, dummy);
        repeat (1000) @(negedge clk);
        chk(rx_n == 0, "R1 truncated start ignored", rx_n, 0);
        op_only(8'h12);
        wait_rx(6, 6000);
        chk(rx_n == 6, "R7 burst drains all words", rx_n, 6);
        foreach (VEC[i]) begin
            chk(rx_w[i] == VEC[i], "R10 R14 decoded word and order", rx_w[i], VEC[i]);
            if (i > 0)
                chk(first_t[i] - first_t[i-1] >= 36 * BIT_HS, "R12 word spacing",
                    32'(first_t[i] - first_t[i-1]), 36 * BIT_HS);
        end
        chk(last_period == BIT_HS, "R11 fast bit period", 32'(last_period), BIT_HS);
        chk(last_width == HALF_HS, "R9 active half width", 32'(last_width), HALF_HS);
        repeat (400) @(negedge clk);
        chk(tflag == 1'b1, "R13 flag empty after burst", tflag, 1);
        rd_status(st);
        chk(st == 8'h01, "R6 status after burst", st, 8'h01);

        // R7 a finished burst does not send later words
        wr_data(32'h0000_00A1);
        repeat (1000) @(negedge clk);
        chk(rx_n == 6, "R7 new word waits for new start", rx_n, 6);
        op_only(8'h12);
        wait_rx(7, 1000);
        chk(rx_n == 7 && rx_w[6] == 32'h0000_00A1, "R7 second start sends", rx_w[6], 32'h0000_00A1);
        repeat (400) @(negedge clk);

        // R4 / R13 / R14 full queue
        wr_ctrl(16'h4000);
        chk(tflag == 1'b0, "R13 flag full mode not full", tflag, 0);
        for (int i = 0; i < 32; i++) wr_data(32'hC0FF_EE00 ^ (32'(i) * 32'h0101_0101));
        chk(tflag == 1'b1, "R13 flag shows full", tflag, 1);
        rd_status(st);
        chk(st == 8'h02, "R6 status full", st, 8'h02);
        wr_data(32'hDEAD_BEEF);
        base = rx_n;
        op_only(8'h12);
        wait_rx(base + 32, 14000);
        repeat (800) @(negedge clk);
        chk(rx_n == base + 32, "R4 overflow word dropped", rx_n, base + 32);
        chk(rx_w[base] == 32'hC0FF_EE00, "R14 first of full queue", rx_w[base], 32'hC0FF_EE00);
        chk(rx_w[base+31] == (32'hC0FF_EE00 ^ (32'd31 * 32'h0101_0101)), "R4 R14 last word kept",
            rx_w[base+31], 32'hC0FF_EE00 ^ (32'd31 * 32'h0101_0101));
        chk(tflag == 1'b0, "R13 flag full mode after drain", tflag, 0);

        // R5 clear
        wr_ctrl(16'h0000);
        wr_data(32'h1111_1111);
        wr_data(32'h2222_2222);
        op_only(8'h02);
        rd_status(st);
        chk(st == 8'h01, "R5 clear empties queue", st, 8'h01);
        rd_ctrl(cr);
        chk(cr == 16'h0000, "R5 clear keeps control", cr, 0);
        base = rx_n;
        op_only(8'h12);
        repeat (1000) @(negedge clk);
        chk(rx_n == base, "R5 nothing sent after clear", rx_n, base);

        // R8 automatic mode
        wr_ctrl(16'h2000);
        wr_data(32'h5A5A_3C81);
        rd_status(st);
        chk(st == 8'h05, "R6 busy bit during auto send", st, 8'h05);
        wait_rx(base + 1, 1000);
        chk(rx_n == base + 1 && rx_w[base] == 32'h5A5A_3C81, "R8 auto send", rx_w[base], 32'h5A5A_3C81);
        repeat (400) @(negedge clk);

        // R11 slow rate
        wr_ctrl(16'h0400);
        wr_data(32'h0000_FF37);
        op_only(8'h12);
        wait_rx(base + 2, 6000);
        chk(rx_w[base+1] == 32'h0000_FF37, "R11 slow word", rx_w[base+1], 32'h0000_FF37);
        chk(last_period == 8 * BIT_HS, "R11 slow bit period", 32'(last_period), 8 * BIT_HS);
        chk(last_width == 8 * HALF_HS, "R9 slow active half width", 32'(last_width), 8 * HALF_HS);

        chk(both_bad == 0, "R9 never both levels", both_bad, 0);
        finish_up();
    end
endmodule